// File: doc/BRIEF.md
# Speculative Renaming Register File

This block sits in the decode stage of an out-of-order core. Each architectural register slot holds one of two things: a finished value, or the tag of the in-flight instruction that will produce it. Decode reads two source registers through two read ports. Each port returns a ready flag together with either the value or the pending tag. A single destination port binds a register to the new tag given to the instruction now being decoded.

Results come back on a broadcast bus that carries a tag and a value. Every slot waiting on that tag captures the value and becomes ready. The same broadcast is forwarded combinationally to both read ports, so a source that completes in the decode cycle is seen as a value, not as a stale tag. After an exception, a restore pulse reloads every slot from the committed architectural values and marks them all ready.

Register 0 is a constant zero. Whether broadcasts are forwarded to the read ports is chosen by a parameter.

Top module: `spec_rename_rf`

## Requirements
- R1: After reset, every register reads as ready with value 0.
- R2: A destination bind of register r (r not 0) to tag t makes reads of r return ready=0 and tag t from the next cycle. While a read is pending, its value output is 0.
- R3: A broadcast with tag t and value v makes every register pending on t read as ready with value v from the next cycle, whatever the number of such registers.
- R4: A broadcast whose tag differs from a register's pending tag leaves that register unchanged. This includes an older tag whose binding was replaced by a later destination bind.
- R5: When a read selects a register pending on the tag being broadcast in the same cycle, the port returns ready=1 and the broadcast value in that cycle.
- R6: When a destination bind and a broadcast that matches the same register's old tag occur in one cycle, the register is left pending on the new tag.
- R7: A restore pulse loads every register r (r not 0) with word r of the committed-value vector (bits r*DATA_W and up) and marks it ready. The restore takes priority over a bind or a broadcast in the same cycle.
- R8: Register 0 always reads as ready with value 0, and a destination bind to register 0 has no effect.
- R9: The two read ports are independent. A read in the same cycle as a bind of the same register returns the state from before that bind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_a_idx | input | IDX_W | Register selected by read port A |
| src_a_ready | output | 1 | Port A operand is a value |
| src_a_value | output | DATA_W | Port A value (0 while pending) |
| src_a_tag | output | TAG_W | Port A producer tag, meaningful when not ready |
| src_b_idx | input | IDX_W | Register selected by read port B |
| src_b_ready | output | 1 | Port B operand is a value |
| src_b_value | output | DATA_W | Port B value (0 while pending) |
| src_b_tag | output | TAG_W | Port B producer tag, meaningful when not ready |
| dst_en | input | 1 | Bind a destination register to a new tag |
| dst_idx | input | IDX_W | Destination register |
| dst_tag | input | TAG_W | New producer tag |
| res_en | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_value | input | DATA_W | Broadcast result value |
| restore_en | input | 1 | Reload all registers from committed state |
| restore_values | input | NREGS*DATA_W | Committed values, register r in word r |

## Verification
The assertions assume only that the control inputs hold known levels after reset. They do not assume that tags are unique. A real allocator never has two live producers sharing a tag, but the properties hold even when it does, because a broadcast simply wakes every slot waiting on that tag. The stimulus therefore draws tags and register indices from small pools. This makes tag reuse, stale-tag broadcasts, binds that collide with broadcasts, and reads of just-woken slots frequent. Restore pulses are rare and land on arbitrary pending states.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

   typedef enum logic [1:0] {
      UPD_HOLD    = 2'd0,
      UPD_RESTORE = 2'd1,
      UPD_BIND    = 2'd2,
      UPD_WAKE    = 2'd3
   } upd_e;

endpackage

// File: rtl/rrf_slot.sv
module rrf_slot
   import rrf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restore_en,
   input  logic [DATA_W-1:0] restore_value,
   input  logic              bind_hit,
   input  logic [TAG_W-1:0]  bind_tag,
   input  logic              res_en,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_value,
   output logic              ready,
   output logic [DATA_W-1:0] value,
   output logic [TAG_W-1:0]  tag
);

   logic              rdy_q;
   logic [DATA_W-1:0] val_q;
   logic [TAG_W-1:0]  tag_q;
   upd_e              upd;

   always_comb begin
      if (restore_en)                              upd = UPD_RESTORE;
      else if (bind_hit)                           upd = UPD_BIND;
      else if (res_en && !rdy_q && tag_q == res_tag) upd = UPD_WAKE;
      else                                         upd = UPD_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b1;
         val_q <= '0;
         tag_q <= '0;
      end else begin
         case (upd)
            UPD_RESTORE: begin
               rdy_q <= 1'b1;
               val_q <= restore_value;
            end
            UPD_BIND: begin
               rdy_q <= 1'b0;
               tag_q <= bind_tag;
            end
            UPD_WAKE: begin
               rdy_q <= 1'b1;
               val_q <= res_value;
            end
            default: ;
         endcase
      end
   end

   assign ready = rdy_q;
   assign value = val_q;
   assign tag   = tag_q;

   p_bind_sets_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_hit && !restore_en) |=> (!ready && tag == $past(bind_tag)));

   p_new_tag_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_hit && res_en && !restore_en) |=> !ready);

   p_wake_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_en && !ready && tag == res_tag && !bind_hit && !restore_en)
      |=> (ready && value == $past(res_value)));

   p_other_tag_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !(res_en && tag == res_tag) && !bind_hit && !restore_en)
      |=> (!ready && $stable(tag)));

   p_restore_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restore_en |=> (ready && value == $past(restore_value)));

endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port #(
   parameter int NREGS  = 16,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5,
   parameter bit BYPASS = 1'b1,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              slot_rdy [NREGS],
   input  logic [DATA_W-1:0] slot_val [NREGS],
   input  logic [TAG_W-1:0]  slot_tag [NREGS],
   input  logic              res_en,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_value,
   output logic              rd_ready,
   output logic [DATA_W-1:0] rd_value,
   output logic [TAG_W-1:0]  rd_tag
);

   logic              sel_rdy;
   logic [DATA_W-1:0] sel_val;
   logic [TAG_W-1:0]  sel_tag;
   logic              fwd;

   assign sel_rdy = slot_rdy[idx];
   assign sel_val = slot_val[idx];
   assign sel_tag = slot_tag[idx];

   generate
      if (BYPASS) begin : g_fwd
         assign fwd = res_en && !sel_rdy && (sel_tag == res_tag);

         p_same_cycle_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (res_en && !sel_rdy && sel_tag == res_tag) |-> (rd_ready && rd_value == res_value));
      end else begin : g_nofwd
         assign fwd = 1'b0;
      end
   endgenerate

   always_comb begin
      rd_ready = sel_rdy | fwd;
      rd_tag   = sel_tag;
      if (sel_rdy)  rd_value = sel_val;
      else if (fwd) rd_value = res_value;
      else          rd_value = '0;
   end

   p_pending_value_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ready |-> (rd_value == '0));

endmodule

// File: rtl/spec_rename_rf.sv
module spec_rename_rf #(
   parameter int NREGS  = 16,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5,
   parameter bit BYPASS = 1'b1,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        src_a_idx,
   output logic                    src_a_ready,
   output logic [DATA_W-1:0]       src_a_value,
   output logic [TAG_W-1:0]        src_a_tag,
   input  logic [IDX_W-1:0]        src_b_idx,
   output logic                    src_b_ready,
   output logic [DATA_W-1:0]       src_b_value,
   output logic [TAG_W-1:0]        src_b_tag,
   input  logic                    dst_en,
   input  logic [IDX_W-1:0]        dst_idx,
   input  logic [TAG_W-1:0]        dst_tag,
   input  logic                    res_en,
   input  logic [TAG_W-1:0]        res_tag,
   input  logic [DATA_W-1:0]       res_value,
   input  logic                    restore_en,
   input  logic [NREGS*DATA_W-1:0] restore_values
);

   generate
      if (NREGS < 2) begin : g_bad_nregs
         $error("spec_rename_rf: NREGS must be at least 2");
      end
      if ((NREGS & (NREGS - 1)) != 0) begin : g_bad_pow2
         $error("spec_rename_rf: NREGS must be a power of two");
      end
      if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("spec_rename_rf: DATA_W and TAG_W must be positive");
      end
   endgenerate

   logic              slot_rdy [NREGS];
   logic [DATA_W-1:0] slot_val [NREGS];
   logic [TAG_W-1:0]  slot_tag [NREGS];

   logic [DATA_W-1:0] unused_word0;
   assign unused_word0 = restore_values[DATA_W-1:0];

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_slot
         if (i == 0) begin : g_zero
            assign slot_rdy[i] = 1'b1;
            assign slot_val[i] = '0;
            assign slot_tag[i] = '0;
         end else begin : g_live
            logic hit;
            assign hit = dst_en && (dst_idx == IDX_W'(i));
            rrf_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
               .clk           (clk),
               .rst_n         (rst_n),
               .restore_en    (restore_en),
               .restore_value (restore_values[i*DATA_W +: DATA_W]),
               .bind_hit      (hit),
               .bind_tag      (dst_tag),
               .res_en        (res_en),
               .res_tag       (res_tag),
               .res_value     (res_value),
               .ready         (slot_rdy[i]),
               .value         (slot_val[i]),
               .tag           (slot_tag[i])
            );
         end
      end
   endgenerate

   rrf_read_port #(.NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS(BYPASS)) u_rd_a (
      .clk (clk), .rst_n (rst_n), .idx (src_a_idx),
      .slot_rdy (slot_rdy), .slot_val (slot_val), .slot_tag (slot_tag),
      .res_en (res_en), .res_tag (res_tag), .res_value (res_value),
      .rd_ready (src_a_ready), .rd_value (src_a_value), .rd_tag (src_a_tag)
   );

   rrf_read_port #(.NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .BYPASS(BYPASS)) u_rd_b (
      .clk (clk), .rst_n (rst_n), .idx (src_b_idx),
      .slot_rdy (slot_rdy), .slot_val (slot_val), .slot_tag (slot_tag),
      .res_en (res_en), .res_tag (res_tag), .res_value (res_value),
      .rd_ready (src_b_ready), .rd_value (src_b_value), .rd_tag (src_b_tag)
   );

   p_reg0_constant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a_idx == '0) |-> (src_a_ready && src_a_value == '0));

   p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src_a_idx == src_b_idx) |-> (src_a_ready == src_b_ready && src_a_value == src_b_value));

endmodule

// File: tb/sim_spec_rename_rf.sv
module sim_spec_rename_rf;

   localparam int NR = 16;
   localparam int DW = 32;
   localparam int TW = 5;
   localparam int IW = $clog2(NR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
   logic          src_a_ready, src_b_ready;
   logic [DW-1:0] src_a_value, src_b_value;
   logic [TW-1:0] src_a_tag, src_b_tag;
   logic          dst_en = 1'b0, res_en = 1'b0, restore_en = 1'b0;
   logic [TW-1:0] dst_tag = '0, res_tag = '0;
   logic [DW-1:0] res_value = '0;
   logic [DW-1:0] commit_w [NR];
   logic [NR*DW-1:0] restore_values;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   bit            m_rdy [NR];
   logic [DW-1:0] m_val [NR];
   logic [TW-1:0] m_tag [NR];

   always #10 clk = ~clk;

   always_comb
      for (int i = 0; i < NR; i++) restore_values[i*DW +: DW] = commit_w[i];

   spec_rename_rf #(.NREGS(NR), .DATA_W(DW), .TAG_W(TW), .BYPASS(1'b1)) u0 (
      .clk, .rst_n,
      .src_a_idx, .src_a_ready, .src_a_value, .src_a_tag,
      .src_b_idx, .src_b_ready, .src_b_value, .src_b_tag,
      .dst_en, .dst_idx, .dst_tag,
      .res_en, .res_tag, .res_value,
      .restore_en, .restore_values
   );

   task automatic check_port(input string lbl, input string port, input logic [IW-1:0] idx,
                             input logic a_rdy, input logic [DW-1:0] a_val, input logic [TW-1:0] a_tag);
      bit            e_rdy;
      logic [DW-1:0] e_val;
      logic [TW-1:0] e_tag;
      e_tag = m_tag[idx];
      if (idx == 0) begin
         e_rdy = 1; e_val = '0;
      end else if (m_rdy[idx]) begin
         e_rdy = 1; e_val = m_val[idx];
      end else if (res_en && m_tag[idx] == res_tag) begin
         e_rdy = 1; e_val = res_value;
      end else begin
         e_rdy = 0; e_val = '0;
      end
      vectors++;
      if (a_rdy !== e_rdy || a_val !== e_val || (!e_rdy && a_tag !== e_tag)) begin
         miscompares++;
         $display("FAIL %s port %s reg %0d: got rdy=%0b val=%h tag=%0d, expected rdy=%0b val=%h tag=%0d",
                  lbl, port, idx, a_rdy, a_val, a_tag, e_rdy, e_val, e_tag);
      end
   endtask

   task automatic model_step();
      for (int i = 1; i < NR; i++) begin
         if (restore_en) begin
            m_rdy[i] = 1; m_val[i] = commit_w[i];
         end else if (dst_en && dst_idx == IW'(i)) begin
            m_rdy[i] = 0; m_tag[i] = dst_tag;
         end else if (res_en && !m_rdy[i] && m_tag[i] == res_tag) begin
            m_rdy[i] = 1; m_val[i] = res_value;
         end
      end
   endtask

   // inputs are set at the falling edge; outputs compared 1 ns later
   task automatic cycle(input string lbl);
      #1;
      check_port(lbl, "A", src_a_idx, src_a_ready, src_a_value, src_a_tag);
      check_port(lbl, "B", src_b_idx, src_b_ready, src_b_value, src_b_tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      dst_en = 0; res_en = 0; restore_en = 0;
   endtask

   task automatic set_rd(input int a, input int b);
      src_a_idx = IW'(a); src_b_idx = IW'(b);
   endtask

   task automatic bind_reg(input int r, input int t);
      dst_en = 1; dst_idx = IW'(r); dst_tag = TW'(t);
   endtask

   task automatic bcast(input int t, input logic [DW-1:0] v);
      res_en = 1; res_tag = TW'(t); res_value = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         m_rdy[i] = 1; m_val[i] = '0; m_tag[i] = '0;
         commit_w[i] = DW'(32'h1000_0000 + i * 32'h111);
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state, all registers on both ports
      for (int i = 0; i < NR; i++) begin
         set_rd(i, NR - 1 - i);
         cycle("R1");
      end

      // R9: read in bind cycle sees old state
      set_rd(3, 3); bind_reg(3, 5); cycle("R9");
      // R2: next cycle pending on tag 5
      cycle("R2");
      // R5: broadcast of tag 5 forwarded the same cycle
      bcast(5, 32'hAAAA_5555); cycle("R5");
      // R3: now ready from storage
      cycle("R3");

      // R3: two registers pending on one tag woken together
      bind_reg(4, 7); cycle("R2");
      bind_reg(5, 7); cycle("R2");
      set_rd(4, 5); bcast(7, 32'h0BAD_F00D); cycle("R5");
      cycle("R3");

      // R4: stale tag after re-bind does not wake
      bind_reg(6, 2); cycle("R2");
      bind_reg(6, 9); cycle("R2");
      set_rd(6, 6); bcast(2, 32'hDEAD_0002); cycle("R4");
      cycle("R4");
      bcast(12, 32'h1234_5678); cycle("R4");
      cycle("R4");

      // R6: bind and matching broadcast on same register
      bind_reg(7, 3); cycle("R2");
      set_rd(7, 7); bind_reg(7, 11); bcast(3, 32'h3333_3333); cycle("R6");
      cycle("R6");

      // R8: bind to register 0 ignored
      set_rd(0, 0); bind_reg(0, 1); cycle("R8");
      cycle("R8");
      bcast(0, 32'hFFFF_FFFF); cycle("R8");

      // R7: restore beats bind and broadcast in the same cycle
      bind_reg(8, 4); cycle("R2");
      set_rd(8, 6); bind_reg(8, 13); bcast(4, 32'h4444_4444); restore_en = 1; cycle("R7");
      for (int i = 0; i < NR; i++) begin
         set_rd(i, (i + 7) % NR);
         cycle("R7");
      end

      // mixed traffic, small tag and register pools
      for (int n = 0; n < 3000; n++) begin
         set_rd($urandom_range(0, 7), $urandom_range(0, 7));
         if ($urandom_range(0, 2) != 0) bind_reg($urandom_range(0, 7), $urandom_range(0, 5));
         if ($urandom_range(0, 1) != 0) bcast($urandom_range(0, 5), DW'($urandom));
         if ($urandom_range(0, 60) == 0) begin
            for (int i = 0; i < NR; i++) commit_w[i] = DW'($urandom);
            restore_en = 1;
         end
         cycle("mixed R2 R3 R4 R5 R6 R7 R8 R9");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule